// File: doc/BRIEF.md
# Two-Wire Bus Target with Pointer-Addressed Register Bank

This block answers as a target device on a two-wire serial bus (clock plus open-drain data). It holds a small bank of byte-wide registers. A host reaches them through an internal index, the register pointer. Both bus lines are first brought into a faster system clock domain. Bus events are then found from the resynchronised history: the start and stop conditions, and the rising and falling edges of the clock line. The system clock must run at least eight times faster than the bus clock.

To write, the host sends the device address with the direction bit clear. The first byte after it sets the pointer. Each further byte lands at the pointer, and the pointer then steps by one, wrapping at the top of the bank. To read, the host usually sets the pointer first and then issues a repeated start with the direction bit set. The target then shifts out registers from the pointer onwards, stepping after each byte, until the host declines a byte. The pointer is kept between transactions, so a bare read carries on where the last access ended. The block's only output onto the bus is a pull-down enable for the data line. A flattened copy of the register bank is also brought out for test.

Top module: `i2cs_target`

## Requirements
- R1: A falling data line while the clock line is high is a START, and a rising data line while the clock is high is a STOP. Either one aborts any partly received byte at once, in any state, so an aborted byte is never stored.
- R2: The address byte is 7 address bits, MSB first, followed by a direction bit (0 = write, 1 = read). When the address equals DEV_ADDR, the target asserts `sda_pd_o` through the ninth (acknowledge) clock.
- R3: When the address does not match, `sda_pd_o` stays low and no register changes until the next START.
- R4: In a write, the first byte after the address loads the pointer with its low 4 bits. Each later byte is stored at the pointer, which then increments and wraps from 15 to 0.
- R5: After an address with the read bit set, the target drives register bytes MSB first, starting at the pointer. The pointer increments after each byte and wraps from 15 to 0.
- R6: When the host answers a read byte with a high level (no acknowledge), the target releases the data line until STOP or START. The next read continues at the advanced pointer.
- R7: Pointer and data bytes of a write are always acknowledged with a low level.
- R8: `sda_pd_o` changes only after a clock-line falling edge (or on a START or STOP), never while the clock line stays high.
- R9: After reset, all 16 registers and the pointer are zero and the data line is released.
- R10: `reg_view_o[8*i+7:8*i]` holds register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pd_o | output | 1 | Pull the data line low when 1 |
| reg_view_o | output | NREG*DW | Flattened register bank for test |

## Verification
A pointer that is wrong shows up within one byte: the next stored byte lands at a different slot of `reg_view_o`, or the next read returns a different register. A bit counter that is off by one moves the acknowledge pulse to another clock, so the host sees no acknowledge. It also shifts read data by a bit, and both are caught on the byte where the fault first occurs. A target that fails to go quiet after a mismatch or a declined byte drives the data line during a later clock. That shows at once as an unexpected acknowledge or as a data-line change while the clock is high.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_RACK
   } bus_st_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_PTR,
      PH_DATA
   } rx_ph_e;
endpackage

// File: rtl/i2cs_busmon.sv
module i2cs_busmon #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cs_busmon: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   logic scl_s;
   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
   parameter int NREG = 16,
   parameter int DW   = 8,
   parameter bit VIEW = 1'b1,
   localparam int PW  = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [PW-1:0]      waddr,
   input  logic [DW-1:0]      wdata,
   input  logic [PW-1:0]      raddr,
   output logic [DW-1:0]      rdata,
   output logic [NREG*DW-1:0] view
);
   logic [DW-1:0] mem [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         mem[i] <= '0;
         else if (we && waddr == PW'(i))     mem[i] <= wdata;
      end
      if (VIEW) begin : g_view
         assign view[i*DW +: DW] = mem[i];
      end else begin : g_noview
         assign view[i*DW +: DW] = '0;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/i2cs_target.sv
module i2cs_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h3A,
   parameter int         NREG        = 16,
   parameter int         DW          = 8,
   parameter int         SYNC_STAGES = 2,
   parameter bit         EXPOSE_VIEW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_pd_o,
   output logic [NREG*DW-1:0] reg_view_o
);
   import i2cs_pkg::*;

   localparam int PW = $clog2(NREG);
   localparam int BW = $clog2(DW);

   if (DW != 8) begin : g_bad_dw
      $error("i2cs_target: DW must be 8");
   end
   if (NREG < 2 || (1 << PW) != NREG) begin : g_bad_nreg
      $error("i2cs_target: NREG must be a power of two");
   end

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2cs_busmon #(.STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   bus_st_e       st;
   rx_ph_e        ph;
   logic [DW-1:0] sh;
   logic [BW-1:0] bitcnt;
   logic [PW-1:0] ptr;
   logic          got, rd, nak;
   logic [DW-1:0] rd_data;
   logic          wr_en, rd_load, quiet;

   assign quiet   = !start_det && !stop_det;
   assign wr_en   = quiet && st == ST_RX && scl_fall && got && ph == PH_DATA;
   assign rd_load = quiet && scl_fall &&
                    ((st == ST_ACK && ph == PH_ADDR && rd) || (st == ST_RACK && !nak));

   i2cs_regbank #(.NREG(NREG), .DW(DW), .VIEW(EXPOSE_VIEW)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr), .wdata(sh),
      .raddr(ptr), .rdata(rd_data), .view(reg_view_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; ph <= PH_ADDR; sh <= '0; bitcnt <= '0; ptr <= '0;
         got <= 1'b0; rd <= 1'b0; nak <= 1'b0; sda_pd_o <= 1'b0;
      end else if (start_det) begin
         st <= ST_RX; ph <= PH_ADDR; bitcnt <= '0; got <= 1'b0; sda_pd_o <= 1'b0;
      end else if (stop_det) begin
         st <= ST_IDLE; bitcnt <= '0; got <= 1'b0; sda_pd_o <= 1'b0;
      end else if (rd_load) begin
         sh       <= rd_data;
         sda_pd_o <= ~rd_data[DW-1];
         ptr      <= ptr + 1'b1;
         bitcnt   <= '0;
         st       <= ST_TX;
      end else begin
         unique case (st)
            ST_RX: begin
               if (scl_rise) begin
                  sh <= {sh[DW-2:0], sda_s};
                  if (bitcnt == BW'(DW-1)) begin
                     got <= 1'b1; bitcnt <= '0;
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end else if (scl_fall && got) begin
                  got <= 1'b0;
                  unique case (ph)
                     PH_ADDR: begin
                        if (sh[DW-1:1] == DEV_ADDR) begin
                           rd <= sh[0]; sda_pd_o <= 1'b1; st <= ST_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end
                     PH_PTR: begin
                        ptr <= sh[PW-1:0]; sda_pd_o <= 1'b1; st <= ST_ACK;
                     end
                     default: begin
                        ptr <= ptr + 1'b1; sda_pd_o <= 1'b1; st <= ST_ACK;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  sda_pd_o <= 1'b0;
                  st       <= ST_RX;
                  ph       <= (ph == PH_ADDR) ? PH_PTR : PH_DATA;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == BW'(DW-1)) begin
                     sda_pd_o <= 1'b0; bitcnt <= '0; st <= ST_RACK;
                  end else begin
                     sh       <= {sh[DW-2:0], 1'b0};
                     sda_pd_o <= ~sh[DW-2];
                     bitcnt   <= bitcnt + 1'b1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise)      nak <= sda_s;
               else if (scl_fall) st  <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_PD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pd_o) |-> $past(scl_fall || start_det || stop_det)) else $error("pd change"); // R8
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_pd_o) else $error("idle drive"); // R3
   AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ptr == PW'($past(ptr) + 1'b1))) else $error("wr ptr"); // R4
   AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load |=> (ptr == PW'($past(ptr) + 1'b1))) else $error("rd ptr"); // R5
   AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_pd_o) && st == ST_ACK) |-> $past(got)) else $error("ack"); // R2
endmodule

// File: tb/sim_i2cs_target.sv
module sim_i2cs_target;
   localparam logic [6:0] ADDR = 7'h3A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_pd;
   logic [127:0] view;
   wire  sda_line = sda_m & ~sda_pd;

   always #2 clk = ~clk;

   i2cs_target #(.DEV_ADDR(ADDR)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_pd_o(sda_pd), .reg_view_o(view)
   );

   int tests = 0, fails = 0, r8_bad = 0;
   logic [7:0] ref_regs [16];
   logic [3:0] ref_ptr = '0;
   logic prev_scl = 1'b1, prev_pd = 1'b0;

   always @(negedge clk) begin
      if (rst_n && scl_m && prev_scl && sda_pd != prev_pd) r8_bad++;
      prev_scl = scl_m;
      prev_pd  = sda_pd;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic q();
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
   endtask

   task automatic put_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      put_bits(b, 8);
      sda_m = 1'b1; q(); scl_m = 1'b1; q();
      acked = ~sda_line;
      q(); scl_m = 1'b0; q();
   endtask

   task automatic recv_byte(input bit ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
      end
      q(); sda_m = ~ack; scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
   endtask

   task automatic cmp_view(input string req);
      int bad = -1;
      for (int i = 0; i < 16; i++) if (view[i*8 +: 8] !== ref_regs[i]) bad = i;
      if (bad < 0) chk(1'b1, req, 0, 0);
      else chk(1'b0, req, int'(view[bad*8 +: 8]), int'(ref_regs[bad]));
   endtask

   task automatic wr_burst(input logic [7:0] p, input int n);
      bit a;
      logic [7:0] d;
      bus_start();
      send_byte({ADDR, 1'b0}, a); chk(a, "R2 addr ack", a, 1);
      send_byte(p, a);            chk(a, "R7 ptr ack", a, 1);
      ref_ptr = p[3:0];
      for (int i = 0; i < n; i++) begin
         d = 8'($urandom());
         send_byte(d, a); chk(a, "R7 data ack", a, 1);
         ref_regs[ref_ptr] = d; ref_ptr = ref_ptr + 1'b1;
      end
      bus_stop();
      cmp_view("R4 R10 stored bytes");
   endtask

   task automatic rd_seq(input int n, input bit set_ptr, input logic [7:0] p);
      bit a;
      logic [7:0] d;
      bus_start();
      if (set_ptr) begin
         send_byte({ADDR, 1'b0}, a); chk(a, "R2 addr ack", a, 1);
         send_byte(p, a);            chk(a, "R7 ptr ack", a, 1);
         ref_ptr = p[3:0];
         bus_start();
      end
      send_byte({ADDR, 1'b1}, a); chk(a, "R2 read addr ack", a, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, d);
         chk(d === ref_regs[ref_ptr], "R5 read data", d, ref_regs[ref_ptr]);
         ref_ptr = ref_ptr + 1'b1;
      end
      q(); q();
      chk(sda_pd == 1'b0, "R6 released after nak", sda_pd, 0);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      bit a;
      void'($urandom(32'h1bad5eed));
      for (int i = 0; i < 16; i++) ref_regs[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(sda_pd == 1'b0, "R9 reset released", sda_pd, 0);
      chk(view == '0, "R9 reset regs zero", int'(view[31:0]), 0);

      // R9 pointer zero after reset: bare read starts at register 0
      rd_seq(1, 1'b0, 8'h00);

      // R4 wrap 15 -> 0, pointer byte masked to low 4 bits
      wr_burst(8'hFF, 3);
      wr_burst(8'h23, 2);

      // R5 read across wrap
      rd_seq(4, 1'b1, 8'h0E);
      // R6 continuation at advanced pointer
      rd_seq(2, 1'b0, 8'h00);

      // R3 wrong address: no ack, no write
      bus_start();
      send_byte({ADDR ^ 7'h01, 1'b0}, a); chk(!a, "R3 no ack mismatch", a, 0);
      send_byte(8'h04, a);                 chk(!a, "R3 ignored byte", a, 0);
      send_byte(8'h5A, a);                 chk(!a, "R3 ignored data", a, 0);
      bus_stop();
      cmp_view("R3 regs unchanged");

      // R1 START mid-byte aborts, then new write works
      bus_start();
      send_byte({ADDR, 1'b0}, a); send_byte(8'h05, a);
      put_bits(8'hC3, 3);
      bus_start();
      send_byte({ADDR, 1'b0}, a); chk(a, "R1 ack after abort start", a, 1);
      send_byte(8'h06, a); send_byte(8'h77, a);
      ref_regs[6] = 8'h77; ref_ptr = 4'd7;
      bus_stop();
      cmp_view("R1 aborted byte not stored");

      // R1 STOP mid-byte aborts
      bus_start();
      send_byte({ADDR, 1'b0}, a); send_byte(8'h09, a);
      put_bits(8'hA5, 4);
      bus_stop();
      ref_ptr = 4'd9;
      cmp_view("R1 stop abort not stored");
      rd_seq(1, 1'b0, 8'h00);

      // constrained random mix
      for (int it = 0; it < 30; it++) begin
         if ($urandom_range(1, 0) == 1)
            wr_burst(8'($urandom_range(31, 0)), int'($urandom_range(5, 1)));
         else
            rd_seq(int'($urandom_range(4, 1)), $urandom_range(1, 0) == 1,
                   8'($urandom_range(31, 0)));
      end

      chk(r8_bad == 0, "R8 sda stable while scl high", r8_bad, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule